// File: doc/BRIEF.md
# Floating-point compare predicate unit

This block compares two IEEE-754 operands and reduces the comparison to a single condition flag. Both operands share one format, either single or double precision, chosen by a select input. A comparison first settles which of four relations holds between the operands: less, equal, greater or unordered. A 3-bit condition code then picks one of eight predicates over that relation. The result is a one-bit flag that the surrounding core places in bit 29 of its status word.

The compare is quiet. A NaN operand of either kind makes the relation unordered. Only a signalling NaN raises the invalid output. The unit is purely combinational, so it fits in the execute stage beside the floating-point datapath. Arithmetic, rounding and format conversion are handled elsewhere.

Top module: `fpcmp_unit`

## Requirements
- R1: Condition code 0 (never) drives `cmp_flag` low for every pair of operands.
- R2: Code 1 drives `cmp_flag` high only when the relation is unordered.
- R3: Code 2 is high on equal. Code 3 is high on equal or unordered.
- R4: Code 4 is high on less. Code 5 is high on less or unordered.
- R5: Code 6 is high on less or equal. Code 7 is high on every relation except greater.
- R6: Only bits [2:0] of `cond_word` choose the predicate. Setting any higher bit does not change `cmp_flag`.
- R7: A NaN in either operand makes the relation unordered. A NaN's exponent is all ones and its fraction is nonzero. A quiet NaN, whose top fraction bit is 1, leaves `cmp_invalid` low.
- R8: A signalling NaN in either operand raises `cmp_invalid`. A signalling NaN has an all-ones exponent, a nonzero fraction and a top fraction bit of 0. The relation stays unordered.
- R9: Positive zero and negative zero compare equal.
- R10: Operands that are not NaN are ordered by sign and magnitude. A negative value is below a positive one, and infinities lie beyond every finite value of the same sign.
- R11: With `dbl_sel` = 0, each operand is a single-precision value in bits [31:0] and bits [63:32] are ignored. With `dbl_sel` = 1, each operand is a double-precision value over all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand (single precision in bits [31:0]) |
| op_b | input | 64 | Second operand (same format as op_a) |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| cond_word | input | 8 | Condition word; bits [2:0] select the predicate |
| cmp_flag | output | 1 | Result of the selected predicate |
| cmp_invalid | output | 1 | High when either operand is a signalling NaN |

## Verification
The assertions assume that operand and select inputs are stable 2-state values between changes, since the checks run on settled combinational values. They do not assume that the upper bits of the condition word or of single-precision operands are zero. The stimulus follows these assumptions: it changes inputs only on one clock edge and samples the outputs half a period later. It also deliberately sets ignored high bits so that their lack of effect is exercised.

// File: rtl/fpcmp_pkg.sv
// fpcmp_pkg: shared types for the compare predicate unit.
// Assumes nothing beyond the IEEE-754 field layout.
package fpcmp_pkg;

    // Raw relation between two operands
    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_t;

    // Predicate codes carried in the low three condition bits
    typedef enum logic [2:0] {
        PRED_NEVER = 3'd0,
        PRED_UN    = 3'd1,
        PRED_EQ    = 3'd2,
        PRED_UEQ   = 3'd3,
        PRED_OLT   = 3'd4,
        PRED_ULT   = 3'd5,
        PRED_OLE   = 3'd6,
        PRED_ULE   = 3'd7
    } pred_t;

endpackage

// File: rtl/fpcmp_classify.sv
// fpcmp_classify: decodes one IEEE-754 operand into NaN, signalling-NaN
// and zero indications. Assumes the standard sign/exponent/fraction packing
// with the quiet bit as the top fraction bit.
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int OP_W = 1 + EXP_W + MAN_W
) (
    input  logic [OP_W-1:0] op,
    output logic            is_nan,
    output logic            is_snan,
    output logic            is_zero
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] frac_f;

    assign exp_f  = op[OP_W-2 -: EXP_W];
    assign frac_f = op[MAN_W-1:0];

    // Field decode of the operand class
    always_comb begin
        is_nan  = (&exp_f) && (|frac_f);
        is_snan = is_nan && !frac_f[MAN_W-1];
        is_zero = (exp_f == '0) && (frac_f == '0);
    end

endmodule

// File: rtl/fpcmp_lane.sv
// fpcmp_lane: computes the four-way relation and the signalling-NaN
// indication for one precision. Assumes both operands use this lane's
// format; NaNs dominate, signed zeros are equal, otherwise sign-magnitude.
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int OP_W  = 1 + EXP_W + MAN_W,
    localparam int MAG_W = OP_W - 1
) (
    input  logic [OP_W-1:0] lane_a,
    input  logic [OP_W-1:0] lane_b,
    output rel_t            lane_rel,
    output logic            lane_snan
);

    logic [OP_W-1:0] ops     [2];
    logic [1:0]      nan_v;
    logic [1:0]      snan_v;
    logic [1:0]      zero_v;

    assign ops[0] = lane_a;
    assign ops[1] = lane_b;

    // One classifier per operand
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .op      (ops[gi]),
            .is_nan  (nan_v[gi]),
            .is_snan (snan_v[gi]),
            .is_zero (zero_v[gi])
        );
    end

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             mag_lt, mag_eq;

    assign sgn_a = lane_a[OP_W-1];
    assign sgn_b = lane_b[OP_W-1];
    assign mag_a = lane_a[MAG_W-1:0];
    assign mag_b = lane_b[MAG_W-1:0];

    // Unsigned magnitude compare; biased exponent keeps infinities on top
    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
    end

    // Relation selection with NaN and signed-zero precedence
    always_comb begin
        if (|nan_v) begin
            lane_rel = REL_UN;
        end else if (&zero_v) begin
            lane_rel = REL_EQ;
        end else if (sgn_a != sgn_b) begin
            lane_rel = sgn_a ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            lane_rel = REL_EQ;
        end else if (sgn_a) begin
            lane_rel = mag_lt ? REL_GT : REL_LT;
        end else begin
            lane_rel = mag_lt ? REL_LT : REL_GT;
        end
    end

    assign lane_snan = |snan_v;

endmodule

// File: rtl/fpcmp_predicate.sv
// fpcmp_predicate: maps a predicate code and a raw relation to the
// condition flag. Assumes the relation is one of the four enum values.
module fpcmp_predicate
    import fpcmp_pkg::*;
(
    input  pred_t pred,
    input  rel_t  rel,
    output logic  flag
);

    logic is_lt, is_eq, is_gt, is_un;

    // One-hot decode of the relation
    always_comb begin
        is_lt = rel == REL_LT;
        is_eq = rel == REL_EQ;
        is_gt = rel == REL_GT;
        is_un = rel == REL_UN;
    end

    // Predicate table
    always_comb begin
        unique case (pred)
            PRED_NEVER: flag = 1'b0;
            PRED_UN:    flag = is_un;
            PRED_EQ:    flag = is_eq;
            PRED_UEQ:   flag = is_eq | is_un;
            PRED_OLT:   flag = is_lt;
            PRED_ULT:   flag = is_lt | is_un;
            PRED_OLE:   flag = is_lt | is_eq;
            PRED_ULE:   flag = !is_gt;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpcmp_unit.sv
// fpcmp_unit: quiet floating-point compare producing one condition flag.
// Assumes both operands share the format chosen by dbl_sel; single values
// sit in the low bits of the operand buses. Purely combinational.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int SP_EXP_W = 8,
    parameter int SP_MAN_W = 23,
    parameter int DP_EXP_W = 11,
    parameter int DP_MAN_W = 52,
    parameter int COND_W   = 8,
    localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W,
    localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W
) (
    input  logic [DP_W-1:0]   op_a,
    input  logic [DP_W-1:0]   op_b,
    input  logic              dbl_sel,
    input  logic [COND_W-1:0] cond_word,
    output logic              cmp_flag,
    output logic              cmp_invalid
);

    rel_t rel_sp, rel_dp, rel_sel;
    logic snan_sp, snan_dp;
    logic unused_cond_hi;

    // Single-precision lane over the low operand bits
    fpcmp_lane #(
        .EXP_W (SP_EXP_W),
        .MAN_W (SP_MAN_W)
    ) u_lane_sp (
        .lane_a    (op_a[SP_W-1:0]),
        .lane_b    (op_b[SP_W-1:0]),
        .lane_rel  (rel_sp),
        .lane_snan (snan_sp)
    );

    // Double-precision lane over the full operand
    fpcmp_lane #(
        .EXP_W (DP_EXP_W),
        .MAN_W (DP_MAN_W)
    ) u_lane_dp (
        .lane_a    (op_a),
        .lane_b    (op_b),
        .lane_rel  (rel_dp),
        .lane_snan (snan_dp)
    );

    // Precision select of relation and invalid indication
    always_comb begin
        rel_sel     = dbl_sel ? rel_dp : rel_sp;
        cmp_invalid = dbl_sel ? snan_dp : snan_sp;
    end

    fpcmp_predicate u_pred (
        .pred (pred_t'(cond_word[2:0])),
        .rel  (rel_sel),
        .flag (cmp_flag)
    );

    assign unused_cond_hi = ^cond_word[COND_W-1:3];

endmodule

// File: rtl/fpcmp_unit_chk.sv
// fpcmp_unit_chk: assertion checker bound into fpcmp_unit. Assumes settled
// 2-state inputs; checks flag against the selected relation.
module fpcmp_unit_chk
    import fpcmp_pkg::*;
#(
    parameter int SP_W = 32,
    parameter int DP_W = 64
) (
    input logic [DP_W-2:0] a_mag,
    input logic [DP_W-2:0] b_mag,
    input logic            dbl_sel,
    input logic [2:0]      code,
    input rel_t            rel_sel,
    input logic            cmp_flag,
    input logic            cmp_invalid
);

    logic a_zero, b_zero;

    // Zero detection from the ports, per precision
    always_comb begin
        a_zero = dbl_sel ? (a_mag == '0) : (a_mag[SP_W-2:0] == '0);
        b_zero = dbl_sel ? (b_mag == '0) : (b_mag[SP_W-2:0] == '0);
    end

    // Settled-value property checks
    always_comb begin
        if (code == 3'd0) begin
            assert_never_low_R1: assert (!cmp_flag)
                else $error("R1 flag high on code 0");
        end
        if (code == 3'd1) begin
            assert_un_match_R2: assert (cmp_flag == (rel_sel == REL_UN))
                else $error("R2 flag mismatch on code 1");
        end
        if (code == 3'd7) begin
            assert_ule_not_gt_R5: assert (cmp_flag == (rel_sel != REL_GT))
                else $error("R5 flag mismatch on code 7");
        end
        if (cmp_invalid) begin
            assert_invalid_unordered_R8: assert (rel_sel == REL_UN)
                else $error("R8 invalid without unordered");
        end
        if (a_zero && b_zero) begin
            assert_signed_zero_eq_R9: assert (rel_sel == REL_EQ)
                else $error("R9 zeros not equal");
        end
    end

endmodule

bind fpcmp_unit fpcmp_unit_chk #(
    .SP_W (SP_W),
    .DP_W (DP_W)
) u_chk (
    .a_mag       (op_a[DP_W-2:0]),
    .b_mag       (op_b[DP_W-2:0]),
    .dbl_sel     (dbl_sel),
    .code        (cond_word[2:0]),
    .rel_sel     (rel_sel),
    .cmp_flag    (cmp_flag),
    .cmp_invalid (cmp_invalid)
);

// File: tb/tb_fpcmp_unit.sv
// tb_fpcmp_unit: scoreboard bench. The driver applies a stimulus on a
// rising edge and queues the expected outputs; the monitor compares on
// the following falling edge.
module tb_fpcmp_unit;

    localparam int HALF = 4;

    // bench relation codes
    localparam int B_LT = 0;
    localparam int B_EQ = 1;
    localparam int B_GT = 2;
    localparam int B_UN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        dbl_sel = 1'b0;
    logic [7:0]  cond_word = '0;
    logic        cmp_flag;
    logic        cmp_invalid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic  exp_flag_q [$];
    logic  exp_inv_q  [$];
    int    code_q     [$];
    string tag_q      [$];

    fpcmp_unit dut (
        .op_a        (op_a),
        .op_b        (op_b),
        .dbl_sel     (dbl_sel),
        .cond_word   (cond_word),
        .cmp_flag    (cmp_flag),
        .cmp_invalid (cmp_invalid)
    );

    always #HALF clk = ~clk;

    // Predicate table taken from R1..R5
    function automatic logic table_flag(int code, int rel);
        case (code)
            0: return 1'b0;
            1: return rel == B_UN;
            2: return rel == B_EQ;
            3: return (rel == B_EQ) || (rel == B_UN);
            4: return rel == B_LT;
            5: return (rel == B_LT) || (rel == B_UN);
            6: return (rel == B_LT) || (rel == B_EQ);
            default: return rel != B_GT;
        endcase
    endfunction

    function automatic string code_req(int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Driver: all eight codes for one operand pair
    task automatic run_pair(input logic [63:0] a, input logic [63:0] b,
                            input logic dbl, input int rel, input logic inv,
                            input logic [4:0] hi, input string tag);
        for (int c = 0; c < 8; c++) begin
            @(posedge clk);
            op_a      = a;
            op_b      = b;
            dbl_sel   = dbl;
            cond_word = {hi, c[2:0]};
            exp_flag_q.push_back(table_flag(c, rel));
            exp_inv_q.push_back(inv);
            code_q.push_back(c);
            tag_q.push_back(tag);
        end
    endtask

    // Monitor: compare settled outputs at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_flag_q.size() > 0) begin
                logic  ef, ei;
                int    cd;
                string tg;
                ef = exp_flag_q.pop_front();
                ei = exp_inv_q.pop_front();
                cd = code_q.pop_front();
                tg = tag_q.pop_front();
                n_checks++;
                if (cmp_flag !== ef) begin
                    n_fails++;
                    $display("FAIL %s (%s) code %0d flag got %b exp %b",
                             code_req(cd), tg, cd, cmp_flag, ef);
                end
                n_checks++;
                if (cmp_invalid !== ei) begin
                    n_fails++;
                    $display("FAIL %s code %0d invalid got %b exp %b",
                             tg, cd, cmp_invalid, ei);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(2 * HALF * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset/idle state: all-zero inputs give flag 0, invalid 0
        @(negedge clk);
        n_checks++;
        if (cmp_flag !== 1'b0 || cmp_invalid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 idle got %b%b exp 00", cmp_flag, cmp_invalid);
        end

        // R10 single-precision ordering
        run_pair(64'h3F800000, 64'h40000000, 0, B_LT, 0, 5'd0, "R10 1<2");
        run_pair(64'h40000000, 64'h3F800000, 0, B_GT, 0, 5'd0, "R10 2>1");
        run_pair(64'hBF800000, 64'h3F800000, 0, B_LT, 0, 5'd0, "R10 -1<1");
        run_pair(64'hC0000000, 64'hBF800000, 0, B_LT, 0, 5'd0, "R10 -2<-1");
        run_pair(64'h7F800000, 64'h7F7FFFFF, 0, B_GT, 0, 5'd0, "R10 inf>max");
        run_pair(64'hFF800000, 64'hFF7FFFFF, 0, B_LT, 0, 5'd0, "R10 -inf<-max");
        run_pair(64'h7F800000, 64'h7F800000, 0, B_EQ, 0, 5'd0, "R10 inf=inf");
        // R9 signed zeros
        run_pair(64'h00000000, 64'h80000000, 0, B_EQ, 0, 5'd0, "R9 sp");
        run_pair(64'h8000000000000000, 64'h0, 1, B_EQ, 0, 5'd0, "R9 dp");
        // R7 quiet NaN, R8 signalling NaN
        run_pair(64'h7FC00000, 64'h3F800000, 0, B_UN, 0, 5'd0, "R7 sp qnan");
        run_pair(64'h3F800000, 64'hFFC00001, 0, B_UN, 0, 5'd0, "R7 sp qnan b");
        run_pair(64'h7F800001, 64'h3F800000, 0, B_UN, 1, 5'd0, "R8 sp snan");
        run_pair(64'h7FF8000000000000, 64'h3FF0000000000000, 1, B_UN, 0,
                 5'd0, "R7 dp qnan");
        run_pair(64'h3FF0000000000000, 64'h7FF0000000000001, 1, B_UN, 1,
                 5'd0, "R8 dp snan");
        // R11 precision select
        run_pair(64'h3FF0000000000000, 64'h4000000000000000, 1, B_LT, 0,
                 5'd0, "R11 dp 1<2");
        run_pair(64'h0000000100000000, 64'h0, 1, B_GT, 0, 5'd0, "R11 dp tiny>0");
        run_pair(64'h0000000100000000, 64'h0, 0, B_EQ, 0, 5'd0, "R11 sp hi ignored");
        run_pair(64'hDEADBEEF3F800000, 64'h123456783F800000, 0, B_EQ, 0,
                 5'd0, "R11 sp garbage hi");
        run_pair(64'h7FF0000100000000, 64'h0, 0, B_EQ, 0, 5'd0, "R11 sp no nan");
        // R6 high condition bits ignored
        run_pair(64'h3F800000, 64'h40000000, 0, B_LT, 0, 5'b10101, "R6 hi set");
        run_pair(64'h7FC00000, 64'h0, 0, B_UN, 0, 5'b11111, "R6 hi all");
        run_pair(64'h40000000, 64'h40000000, 0, B_EQ, 0, 5'b01010, "R6 eq");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule